// File: doc/BRIEF.md
# Safety Error Status Aggregator

This block gathers single-cycle error pulses from three protected areas of a network controller and holds them in three 32-bit sticky status banks: one for the core datapath and state-machine checks, one for the queue-layer memories, and one for the DMA segmentation-offload memory. Software reads the banks through a small register port and clears bits by writing ones to them. A capture-control register decides which classes of event are recorded at all.

From the banks, the block derives a five-bit summary that separates correctable from uncorrectable conditions. It also drives a single registered interrupt line. Every uncorrectable condition reaches that line. A correctable memory error reaches it only when the interrupt enable for that memory is set.

The register port decodes a 3-bit word address. Address 0 is the core bank, 1 the queue bank, 2 the DMA bank, 3 capture control, 4 interrupt enables and 5 the read-only summary. Any other address reads zero. Writes take effect at the clock edge where `reg_we` is high. Reads are combinational from `reg_addr`.

Top module: `safety_err_agg`

## Requirements
- R1: After reset, every register at addresses 0 to 5 reads zero and `irq_o` is low.
- R2: A write of ones to address 0, 1 or 2 clears those status bits. Bits written as zero are left unchanged.
- R3: An error pulse on a bit in the same cycle as a write-one-to-clear of that bit leaves the bit set.
- R4: Bits 20–23 and 25–31 of the core bank always read zero. Bits 3, 7, 11 and 15–31 of the queue bank always read zero. Bits 3–31 of the DMA bank always read zero.
- R5: Core-bank capture is gated by capture-control bit 5 and bit 6. Bit 5 (parity) gates bits 0–7 and 24. Bit 6 (timeout) gates bits 8–19.
- R6: Queue-bank capture is gated per memory by capture-control bits 0–3: bit 0 for bits 0–2, bit 1 for bits 4–6, bit 2 for bits 8–10 and bit 3 for bits 12–14. Capture-control bit 4 gates DMA bits 0–2. In each 3-bit group, the lowest bit is correctable, the middle bit is an address mismatch and the top bit is uncorrectable.
- R7: The summary at address 5 is laid out as follows. Bit 0 is any core-bank bit. Bit 1 is any queue correctable bit. Bit 2 is any queue mismatch or uncorrectable bit. Bit 3 is DMA bit 0. Bit 4 is DMA bit 1 or bit 2.
- R8: Any set uncorrectable summary bit (0, 2 or 4) raises `irq_o`, whatever the interrupt enables hold.
- R9: A correctable memory error raises `irq_o` only while its interrupt-enable bit (address 4) is set. Bits 0 to 3 cover the TX, RX, scheduler and parser queue memories, and bit 4 covers the DMA offload memory.
- R10: A pulse captured at a clock edge is readable right after that edge. `irq_o` follows the status one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_err_i | input | 32 | Core datapath and state-machine error pulses |
| qmem_err_i | input | 32 | Queue memory error pulses |
| dma_err_i | input | 32 | DMA memory error pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq_o | output | 1 | Registered safety interrupt |

## Verification
The bench builds the block with its default parameters: four queue memories with a four-bit stride and 32-bit banks. These values place every reserved slot of the queue layout, including the gap bit in each group, inside the tested range. With all-ones pulses under different capture masks, each group's gating and each reserved bit show up in a single read. Holding one memory's correctable bit while toggling its enable isolates the enabled-interrupt path from the uncorrectable path that is always on.

// File: rtl/sea_pkg.sv
package sea_pkg;
  localparam int DW       = 32;
  localparam int AW       = 3;
  localparam int QMEMS    = 4;
  localparam int QSTRIDE  = 4;
  localparam int QFLAGS   = 3;
  localparam int CAP_W    = QMEMS + 3;
  localparam int IEN_W    = QMEMS + 1;
  localparam int CAP_OFF  = QMEMS;
  localparam int CAP_PAR  = QMEMS + 1;
  localparam int CAP_TMO  = QMEMS + 2;

  localparam logic [AW-1:0] A_MAC  = 3'd0;
  localparam logic [AW-1:0] A_QMEM = 3'd1;
  localparam logic [AW-1:0] A_DMA  = 3'd2;
  localparam logic [AW-1:0] A_CAP  = 3'd3;
  localparam logic [AW-1:0] A_IEN  = 3'd4;
  localparam logic [AW-1:0] A_SUM  = 3'd5;

  localparam logic [DW-1:0] MAC_PAR_MASK = 32'h0100_00FF;
  localparam logic [DW-1:0] MAC_TMO_MASK = 32'h000F_FF00;
  localparam logic [DW-1:0] MAC_VALID    = MAC_PAR_MASK | MAC_TMO_MASK;
  localparam logic [DW-1:0] DMA_VALID    = (DW'(1) << QFLAGS) - DW'(1);

  function automatic logic [DW-1:0] qmem_valid();
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < QMEMS; i++)
      m |= DMA_VALID << (i * QSTRIDE);
    return m;
  endfunction

  typedef struct packed {
    logic dma_unc;
    logic dma_cor;
    logic q_unc;
    logic q_cor;
    logic core;
  } sum_t;
endpackage

// File: rtl/sea_bank.sv
module sea_bank
  import sea_pkg::*;
#(
  parameter logic [DW-1:0] VALID = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] err_i,
  input  logic [DW-1:0] cap_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] stat_o
);
  logic [DW-1:0] stat_q, stat_d, set_v;
  logic          en;

  always_comb begin
    set_v  = err_i & cap_i & VALID;
    // set takes precedence over a simultaneous clear
    stat_d = (stat_q & ~clr_i) | set_v;
    en     = (|clr_i) | (|set_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  stat_q <= '0;
    else if (en) stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/sea_summary.sv
module sea_summary
  import sea_pkg::*;
(
  input  logic [DW-1:0]    mac_i,
  input  logic [DW-1:0]    q_i,
  input  logic [DW-1:0]    dma_i,
  input  logic [IEN_W-1:0] ien_i,
  output sum_t             sum_o,
  output logic             irq_d_o
);
  localparam int QSPAN = QMEMS * QSTRIDE;

  logic [QMEMS-1:0] cor_v, unc_v, irq_v;

  generate
    for (genvar m = 0; m < QMEMS; m++) begin : g_mem
      assign cor_v[m] = q_i[m*QSTRIDE];
      assign unc_v[m] = |q_i[m*QSTRIDE+1 +: QSTRIDE-1];
      assign irq_v[m] = cor_v[m] & ien_i[m];
    end
  endgenerate

  always_comb begin
    sum_o.core    = |mac_i;
    sum_o.q_cor   = |cor_v;
    sum_o.q_unc   = (|unc_v) | (|q_i[DW-1:QSPAN]);
    sum_o.dma_cor = dma_i[0];
    sum_o.dma_unc = |dma_i[DW-1:1];
    irq_d_o = sum_o.core | sum_o.q_unc | sum_o.dma_unc | (|irq_v)
            | (sum_o.dma_cor & ien_i[QMEMS]);
  end
endmodule

// File: rtl/safety_err_agg.sv
module safety_err_agg
  import sea_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   mac_err_i,
  input  logic [31:0]   qmem_err_i,
  input  logic [31:0]   dma_err_i,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq_o
);
  logic [CAP_W-1:0] cap_q, cap_d;
  logic [IEN_W-1:0] ien_q, ien_d;
  logic             cap_en, ien_en;
  logic             irq_q, irq_d;
  logic [DW-1:0]    mac_clr, q_clr, dma_clr;
  logic [DW-1:0]    mac_cap, q_cap, dma_cap;
  logic [DW-1:0]    mac_stat, q_stat, dma_stat;
  sum_t             sum;

  // write decode
  always_comb begin
    mac_clr = (reg_we && reg_addr == A_MAC)  ? reg_wdata : '0;
    q_clr   = (reg_we && reg_addr == A_QMEM) ? reg_wdata : '0;
    dma_clr = (reg_we && reg_addr == A_DMA)  ? reg_wdata : '0;
    cap_en  = reg_we && reg_addr == A_CAP;
    ien_en  = reg_we && reg_addr == A_IEN;
    cap_d   = reg_wdata[CAP_W-1:0];
    ien_d   = reg_wdata[IEN_W-1:0];
  end

  // capture masks
  always_comb begin
    mac_cap = ({DW{cap_q[CAP_PAR]}} & MAC_PAR_MASK)
            | ({DW{cap_q[CAP_TMO]}} & MAC_TMO_MASK);
    dma_cap = {DW{cap_q[CAP_OFF]}} & DMA_VALID;
  end

  generate
    for (genvar m = 0; m < QMEMS; m++) begin : g_qcap
      assign q_cap[m*QSTRIDE +: QSTRIDE] = {QSTRIDE{cap_q[m]}};
    end
    if (QMEMS * QSTRIDE < DW) begin : g_qcap_hi
      assign q_cap[DW-1:QMEMS*QSTRIDE] = '0;
    end
  endgenerate

  sea_bank #(.VALID(MAC_VALID)) u_mac (
    .clk(clk), .rst_n(rst_n), .err_i(mac_err_i), .cap_i(mac_cap),
    .clr_i(mac_clr), .stat_o(mac_stat));

  sea_bank #(.VALID(qmem_valid())) u_qmem (
    .clk(clk), .rst_n(rst_n), .err_i(qmem_err_i), .cap_i(q_cap),
    .clr_i(q_clr), .stat_o(q_stat));

  sea_bank #(.VALID(DMA_VALID)) u_dma (
    .clk(clk), .rst_n(rst_n), .err_i(dma_err_i), .cap_i(dma_cap),
    .clr_i(dma_clr), .stat_o(dma_stat));

  sea_summary u_sum (
    .mac_i(mac_stat), .q_i(q_stat), .dma_i(dma_stat), .ien_i(ien_q),
    .sum_o(sum), .irq_d_o(irq_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= cap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_en) ien_q <= ien_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  // read mux
  always_comb begin
    case (reg_addr)
      A_MAC:   reg_rdata = mac_stat;
      A_QMEM:  reg_rdata = q_stat;
      A_DMA:   reg_rdata = dma_stat;
      A_CAP:   reg_rdata = DW'(cap_q);
      A_IEN:   reg_rdata = DW'(ien_q);
      A_SUM:   reg_rdata = DW'(sum);
      default: reg_rdata = '0;
    endcase
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/sea_chk.sv
module sea_chk
  import sea_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] mac_err_i,
  input logic [DW-1:0] mac_cap,
  input logic [DW-1:0] mac_clr,
  input logic [DW-1:0] mac_stat,
  input logic [DW-1:0] q_stat,
  input logic [DW-1:0] dma_stat,
  input sum_t          sum,
  input logic          irq_o
);
  // R4
  mac_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_stat & ~MAC_VALID) == '0);

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mac_err_i & mac_cap)) |=>
      ((mac_stat & $past(mac_err_i & mac_cap)) == $past(mac_err_i & mac_cap)));

  // R2
  keep_zero_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(mac_stat) & ~$past(mac_clr)) & ~mac_stat) == '0));

  // R8
  unc_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum.core || sum.q_unc || sum.dma_unc) |=> irq_o);

  // R10
  idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_stat == '0 && q_stat == '0 && dma_stat == '0) |=> !irq_o);
endmodule

bind safety_err_agg sea_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mac_err_i(mac_err_i), .mac_cap(mac_cap),
  .mac_clr(mac_clr), .mac_stat(mac_stat), .q_stat(q_stat),
  .dma_stat(dma_stat), .sum(sum), .irq_o(irq_o));

// File: tb/safety_err_agg_tb.sv
`timescale 1ns/1ps
module safety_err_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] mac_err_i, qmem_err_i, dma_err_i;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_o;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  safety_err_agg u_dut (
    .clk(clk), .rst_n(rst_n), .mac_err_i(mac_err_i), .qmem_err_i(qmem_err_i),
    .dma_err_i(dma_err_i), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #0.2;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic fire(input logic [31:0] m, input logic [31:0] q, input logic [31:0] d,
                      input logic we, input logic [2:0] a, input logic [31:0] wd);
    @(negedge clk);
    mac_err_i = m; qmem_err_i = q; dma_err_i = d;
    reg_we = we; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    mac_err_i = '0; qmem_err_i = '0; dma_err_i = '0; reg_we = 1'b0;
  endtask

  task automatic clear_all();
    wr(3'd0, '1); wr(3'd1, '1); wr(3'd2, '1);
    step(); step();
  endtask

  task automatic t_reset();
    for (int a = 0; a < 6; a++) rdchk(3'(a), 32'h0, "R1 reset register");
    chk("R1 reset irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_gated_off();
    fire('1, '1, '1, 1'b0, 3'd0, '0);
    rdchk(3'd0, 32'h0, "R5 core gated off");
    rdchk(3'd1, 32'h0, "R6 queue gated off");
    rdchk(3'd2, 32'h0, "R6 dma gated off");
    step();
    chk("R5 irq gated off", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_core_capture();
    wr(3'd3, 32'h7F);
    fire('1, '0, '0, 1'b0, 3'd0, '0);
    rdchk(3'd0, 32'h010F_FFFF, "R4 core reserved bits");
    rdchk(3'd5, 32'h01, "R7 core summary");
    chk("R10 irq not yet", {31'b0, irq_o}, 32'h0);
    step();
    chk("R8 core irq", {31'b0, irq_o}, 32'h1);
  endtask

  task automatic t_w1c();
    wr(3'd0, 32'h0000_00FF);
    rdchk(3'd0, 32'h010F_FF00, "R2 partial clear");
    wr(3'd0, 32'h0);
    rdchk(3'd0, 32'h010F_FF00, "R2 zero write keeps");
    wr(3'd0, '1);
    rdchk(3'd0, 32'h0, "R2 full clear");
    step();
    chk("R10 irq drops", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_set_wins();
    fire(32'h8, '0, '0, 1'b0, 3'd0, '0);
    fire(32'h8, '0, '0, 1'b1, 3'd0, 32'h8);
    rdchk(3'd0, 32'h8, "R3 set beats clear");
    wr(3'd0, 32'h8);
    rdchk(3'd0, 32'h0, "R3 later clear");
    step(); step();
  endtask

  task automatic t_mac_gates();
    wr(3'd3, 32'h40);
    fire('1, '0, '0, 1'b0, 3'd0, '0);
    rdchk(3'd0, 32'h000F_FF00, "R5 timeout only");
    wr(3'd3, 32'h20);
    fire('1, '0, '0, 1'b0, 3'd0, '0);
    rdchk(3'd0, 32'h010F_FFFF, "R5 parity added");
    clear_all();
  endtask

  task automatic t_queue();
    wr(3'd3, 32'h7F);
    wr(3'd4, 32'h0);
    fire('0, 32'h1, '0, 1'b0, 3'd0, '0);
    rdchk(3'd1, 32'h1, "R6 tx correctable");
    rdchk(3'd5, 32'h02, "R7 queue correctable summary");
    step();
    chk("R9 masked correctable", {31'b0, irq_o}, 32'h0);
    wr(3'd4, 32'h1);
    step();
    chk("R9 enabled correctable", {31'b0, irq_o}, 32'h1);
    wr(3'd1, '1);
    step();
    chk("R9 irq after clear", {31'b0, irq_o}, 32'h0);
    fire('0, '1, '0, 1'b0, 3'd0, '0);
    rdchk(3'd1, 32'h0000_7777, "R4 queue reserved bits");
    rdchk(3'd5, 32'h06, "R7 queue both classes");
    wr(3'd1, '1);
    wr(3'd3, 32'h7D);
    fire('0, '1, '0, 1'b0, 3'd0, '0);
    rdchk(3'd1, 32'h0000_7707, "R6 rx memory gated");
    wr(3'd3, 32'h7F);
    clear_all();
  endtask

  task automatic t_dma();
    wr(3'd4, 32'h0);
    fire('0, '0, 32'h1, 1'b0, 3'd0, '0);
    rdchk(3'd2, 32'h1, "R6 dma correctable");
    rdchk(3'd5, 32'h08, "R7 dma correctable summary");
    step();
    chk("R9 dma masked", {31'b0, irq_o}, 32'h0);
    wr(3'd4, 32'h10);
    step();
    chk("R9 dma enabled", {31'b0, irq_o}, 32'h1);
    wr(3'd2, '1);
    fire('0, '0, '1, 1'b0, 3'd0, '0);
    rdchk(3'd2, 32'h7, "R4 dma reserved bits");
    rdchk(3'd5, 32'h18, "R7 dma both classes");
    clear_all();
  endtask

  task automatic t_unc_always();
    wr(3'd4, 32'h0);
    fire('0, 32'h2, '0, 1'b0, 3'd0, '0);
    rdchk(3'd5, 32'h04, "R7 mismatch is uncorrectable");
    step();
    chk("R8 irq with enables off", {31'b0, irq_o}, 32'h1);
    clear_all();
    chk("R8 irq cleared", {31'b0, irq_o}, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    mac_err_i = '0; qmem_err_i = '0; dma_err_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_gated_off();
    t_core_capture();
    t_w1c();
    t_set_wins();
    t_mac_gates();
    t_queue();
    t_dma();
    t_unc_always();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule